// File: doc/BRIEF.md
# Fixed Off-Time Peak-Current Chopper

This block limits the peak current in one H-bridge. An external sense comparator reports, as a synchronous logic level, that the winding current has reached its limit. When that report is accepted, the block raises a chop signal. The chop signal turns the high-side (source) driver off and turns on the low-side device as a synchronous rectifier, so the current decays slowly. After a fixed off time the chop signal falls and a new on-cycle starts with the diagonal pair driven again.

A blanking window masks the comparator after every output switching event, so that recovery spikes and load-capacitance transients are not taken as a trip. The end of each off time counts as a switching event. An active-low overcurrent flag is held by a retriggerable timer, which every trip restarts. During steady chopping the flag therefore stays low without gaps. The flag is informational only and has no effect on the chopper.

All durations are counted in clock cycles. The counts are derived from a clock-frequency parameter in MHz together with parameters for the blank time (ns), the off time (µs) and the flag hold time (µs). Their defaults are 3000 ns, 30 µs and 300 µs.

Top module: `chop_limiter`

## Requirements
- R1: After reset, `chopOff` is 0 and `faultN` is 1.
- R2: When `overThresh` is sampled high on a clock edge while the bridge is enabled, no off time is running and no blanking applies, `chopOff` is 1 from the following cycle.
- R3: After a trip, `chopOff` stays high for exactly OFF_CYC cycles (CLK_MHZ*OFF_US) and then returns to 0, provided the bridge stays enabled.
- R4: A comparator assertion sampled during an off time is ignored and does not extend that off time.
- R5: Consider a `switchEvt` pulse sampled on edge s. The comparator is ignored on edges s through s+BLANK_CYC, where BLANK_CYC is CLK_MHZ*BLANK_NS/1000. It is first accepted on edge s+BLANK_CYC+1.
- R6: The end of an off time opens the same blanking window. The edge on which `chopOff` falls plays the role of s.
- R7: `faultN` falls in the same cycle that a trip raises `chopOff`. It rises exactly HOLD_CYC cycles (CLK_MHZ*HOLD_US) after the last trip.
- R8: Every trip restarts the flag timer from zero. A trip that comes before the timer expires therefore keeps `faultN` low beyond the first expiry point.
- R9: With `bridgeEn` low, `chopOff` is 0 from the next cycle. The comparator and `switchEvt` are ignored, and any off time or blanking is cancelled, so after re-enable a comparator assertion trips at once. The flag timer keeps running and releases on schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bridgeEn | input | 1 | Bridge enabled (low when the bridge is off, asleep or protected) |
| switchEvt | input | 1 | One-cycle marker of an output switching event |
| overThresh | input | 1 | Synchronous sense-comparator result, high at or above the limit |
| chopOff | output | 1 | High forces the source off, with slow decay through the low side |
| faultN | output | 1 | Overcurrent flag, active low |

## Verification
A blanking counter stuck at a wrong value shows up on the first trip after a switch or after an off time. `chopOff` then rises one or more cycles too early or too late at the window edge. The bench probes both sides of that edge. A wrong off-time count or a lost retrigger changes the exact cycle on which `chopOff` falls or `faultN` rises. These are checked to the cycle, up to one flag hold period after the last trip. A clear path that misses a counter leaves a trip pending across a disable, which shows within one cycle of the disable or of the re-enable.

// File: rtl/chop_pkg.sv
package chop_pkg;

  // Strobes from the control FSM to the counter datapath
  typedef struct packed {
    logic clearAll;   // bridge disabled: drop off-time and blanking state
    logic loadBlank;  // start a blanking window
    logic loadOff;    // start a fixed off time
    logic loadHold;   // (re)start the flag hold timer
  } chopStrobe_t;

endpackage

// File: rtl/chop_dncnt.sv
// Loadable down-counter with an optional clear; busy while non-zero.
module chop_dncnt #(
  parameter int LOAD_VAL  = 4,
  parameter bit CLEARABLE = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic load,
  output logic busy
);
  localparam int W = $clog2(LOAD_VAL + 2);
  localparam logic [W-1:0] LOADV = W'(LOAD_VAL);

  logic [W-1:0] cnt;
  logic         clrEff;

  generate
    if (CLEARABLE) begin : g_clr
      assign clrEff = clr;
    end else begin : g_noclr
      assign clrEff = 1'b0;
      logic unusedClr;
      assign unusedClr = clr;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (clrEff)      cnt <= '0;
    else if (load)        cnt <= LOADV;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/chop_cnt.sv
// Datapath: blanking, off-time and flag-hold counters.
module chop_cnt
  import chop_pkg::*;
#(
  parameter int BLANK_CYC = 375,
  parameter int OFF_CYC   = 3750,
  parameter int HOLD_CYC  = 37500
) (
  input  logic        clk,
  input  logic        rstN,
  input  chopStrobe_t stb,
  output logic        blankBusy,
  output logic        offLast,
  output logic        holdBusy
);
  logic offBusy;

  chop_dncnt #(.LOAD_VAL(BLANK_CYC), .CLEARABLE(1'b1)) blank_i (
    .clk(clk), .rstN(rstN), .clr(stb.clearAll), .load(stb.loadBlank), .busy(blankBusy)
  );

  // Loaded with OFF_CYC-1 so that the off phase spans OFF_CYC cycles
  chop_dncnt #(.LOAD_VAL(OFF_CYC - 1), .CLEARABLE(1'b1)) off_i (
    .clk(clk), .rstN(rstN), .clr(stb.clearAll), .load(stb.loadOff), .busy(offBusy)
  );

  // Flag hold keeps running through a disable
  chop_dncnt #(.LOAD_VAL(HOLD_CYC), .CLEARABLE(1'b0)) hold_i (
    .clk(clk), .rstN(rstN), .clr(stb.clearAll), .load(stb.loadHold), .busy(holdBusy)
  );

  assign offLast = !offBusy;
endmodule

// File: rtl/chop_ctrl.sv
// Control: on/off phase and strobe generation.
module chop_ctrl
  import chop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bridgeEn,
  input  logic        switchEvt,
  input  logic        overThresh,
  input  logic        blankBusy,
  input  logic        offLast,
  output chopStrobe_t stb,
  output logic        offPhase
);
  logic tripNow;
  logic endOff;

  always_comb begin
    tripNow = bridgeEn && !offPhase && overThresh && !switchEvt && !blankBusy;
    endOff  = bridgeEn && offPhase && offLast;
    stb.clearAll  = !bridgeEn;
    stb.loadBlank = bridgeEn && (switchEvt || endOff);
    stb.loadOff   = tripNow;
    stb.loadHold  = tripNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          offPhase <= 1'b0;
    else if (!bridgeEn) offPhase <= 1'b0;
    else if (tripNow)   offPhase <= 1'b1;
    else if (endOff)    offPhase <= 1'b0;
  end
endmodule

// File: rtl/chop_limiter.sv
// Top: fixed off-time peak-current chopper for one bridge.
module chop_limiter
  import chop_pkg::*;
#(
  parameter int CLK_MHZ  = 125,
  parameter int BLANK_NS = 3000,
  parameter int OFF_US   = 30,
  parameter int HOLD_US  = 300
) (
  input  logic clk,
  input  logic rstN,
  input  logic bridgeEn,
  input  logic switchEvt,
  input  logic overThresh,
  output logic chopOff,
  output logic faultN
);
  localparam int BLANK_CYC = CLK_MHZ * BLANK_NS / 1000;
  localparam int OFF_CYC   = CLK_MHZ * OFF_US;
  localparam int HOLD_CYC  = CLK_MHZ * HOLD_US;

  chopStrobe_t stb;
  logic blankBusy, offLast, holdBusy, offPhase;

  chop_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .bridgeEn(bridgeEn), .switchEvt(switchEvt),
    .overThresh(overThresh), .blankBusy(blankBusy), .offLast(offLast),
    .stb(stb), .offPhase(offPhase)
  );

  chop_cnt #(.BLANK_CYC(BLANK_CYC), .OFF_CYC(OFF_CYC), .HOLD_CYC(HOLD_CYC)) cnt_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .blankBusy(blankBusy), .offLast(offLast), .holdBusy(holdBusy)
  );

  assign chopOff = offPhase;
  assign faultN  = !holdBusy;
endmodule

// File: rtl/chop_limiter_chk.sv
module chop_limiter_chk #(
  parameter int OFF_CYC  = 3750,
  parameter int HOLD_CYC = 37500
) (
  input logic clk,
  input logic rstN,
  input logic bridgeEn,
  input logic switchEvt,
  input logic chopOff,
  input logic faultN
);
  localparam int RW = $clog2(OFF_CYC + 2);
  localparam int TW = $clog2(HOLD_CYC + 2);

  logic [RW-1:0] runCnt;     // cycles chopOff has been high
  logic [TW-1:0] sinceTrip;  // cycles since the last trip (saturating)
  logic          prevChop;
  logic          tripSeen;

  assign tripSeen = chopOff && !prevChop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt    <= '0;
      sinceTrip <= TW'(HOLD_CYC);
      prevChop  <= 1'b0;
    end else begin
      prevChop <= chopOff;
      if (!chopOff)                         runCnt <= '0;
      else if (runCnt != RW'(OFF_CYC + 1))  runCnt <= runCnt + 1'b1;
      if (tripSeen)                            sinceTrip <= TW'(1);
      else if (sinceTrip != TW'(HOLD_CYC + 1)) sinceTrip <= sinceTrip + 1'b1;
    end
  end

  // R3: a natural end of the off time comes after exactly OFF_CYC cycles
  a_r3_off_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(chopOff) && $past(bridgeEn) |-> runCnt == RW'(OFF_CYC));

  // R4: the off time is never extended
  a_r4_no_extend: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= RW'(OFF_CYC));

  // R5: a switch event blocks a trip on the same edge
  a_r5_switch_blanks: assert property (@(posedge clk) disable iff (!rstN)
    switchEvt |=> !$rose(chopOff));

  // R7: the flag falls together with a trip
  a_r7_flag_with_trip: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chopOff) |-> !faultN);

  // R7: the flag releases exactly HOLD_CYC cycles after the last trip
  a_r7_release_time: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultN) |-> sinceTrip == TW'(HOLD_CYC));

  // R8: the flag stays low within the hold period of any trip
  a_r8_hold_low: assert property (@(posedge clk) disable iff (!rstN)
    tripSeen || (sinceTrip < TW'(HOLD_CYC)) |-> !faultN);

  // R9: disable drops the chop signal on the next cycle
  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
    !bridgeEn |=> !chopOff);
endmodule

bind chop_limiter chop_limiter_chk #(.OFF_CYC(OFF_CYC), .HOLD_CYC(HOLD_CYC)) chk_i (
  .clk(clk), .rstN(rstN), .bridgeEn(bridgeEn), .switchEvt(switchEvt),
  .chopOff(chopOff), .faultN(faultN)
);

// File: tb/chop_limiter_tb_top.sv
`timescale 1ns/1ps
module chop_limiter_tb_top;
  // Scaled timebase: counts derived for a 10 MHz parameter, clocked at 125 MHz
  localparam int CLK_MHZ = 10;
  localparam int B = CLK_MHZ * 3000 / 1000;  // 30
  localparam int N = CLK_MHZ * 30;           // 300
  localparam int H = CLK_MHZ * 300;          // 3000

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bridgeEn = 1'b0;
  logic switchEvt = 1'b0;
  logic overThresh = 1'b0;
  logic chopOff, faultN;

  always #4 clk = ~clk;

  chop_limiter #(.CLK_MHZ(CLK_MHZ)) dut_i (
    .clk(clk), .rstN(rstN), .bridgeEn(bridgeEn), .switchEvt(switchEvt),
    .overThresh(overThresh), .chopOff(chopOff), .faultN(faultN)
  );

  typedef struct {
    int    cyc;
    bit    isFlt;
    bit    val;
    string tag;
  } exp_t;

  exp_t sbq[$];
  exp_t cur;
  int cycCnt = 0;
  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always @(posedge clk) cycCnt <= cycCnt + 1;

  task automatic check(string tag, bit act, bit expv, string what);
    testCnt++;
    if (act !== expv) begin
      failCnt++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", tag, what, cycCnt, act, expv);
    end
  endtask

  task automatic push(int c, bit isFlt, bit v, string tag);
    exp_t e;
    e.cyc = c; e.isFlt = isFlt; e.val = v; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic waitTo(int c);
    while (cycCnt < c) @(negedge clk);
  endtask

  // Monitor: pop due expectations and compare, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      while (sbq.size() > 0 && sbq[0].cyc <= cycCnt) begin
        cur = sbq.pop_front();
        check(cur.tag, cur.isFlt ? faultN : chopOff, cur.val, cur.isFlt ? "faultN" : "chopOff");
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog expired at cycle %0d", cycCnt);
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int n;
    int k2;
    bridgeEn = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", chopOff, 1'b0, "chopOff");
    check("R1", faultN, 1'b1, "faultN");

    // Scenario A: trip, off length, ignore during off, blank after off, retrigger
    @(negedge clk);
    n = cycCnt;
    k2 = n + N + B + 2;
    push(n + 1, 0, 1, "R2");
    push(n + 1, 1, 0, "R7");
    push(n + N, 0, 1, "R3");
    push(n + N + 1, 0, 0, "R4");
    push(n + N + B + 1, 0, 0, "R6");
    push(n + N + B + 2, 0, 1, "R6");
    push(n + 1 + H, 1, 0, "R8");
    push(k2 + H - 1, 1, 0, "R7");
    push(k2 + H, 1, 1, "R7");
    overThresh = 1'b1;
    waitTo(n + 1);     overThresh = 1'b0;
    waitTo(n + 100);   overThresh = 1'b1;   // R4: sampled during off
    waitTo(n + 101);   overThresh = 1'b0;
    waitTo(n + N + B); overThresh = 1'b1;   // R6: one edge inside, one outside
    waitTo(n + N + B + 2); overThresh = 1'b0;
    waitTo(k2 + H + 2);

    // Scenario B: blanking after a switch event (R5)
    n = cycCnt;
    push(n + B + 1, 0, 0, "R5");
    push(n + B + 1, 1, 1, "R5");
    push(n + B + 2, 0, 1, "R5");
    switchEvt = 1'b1; overThresh = 1'b1;
    waitTo(n + 1);         switchEvt = 1'b0;
    waitTo(n + B + 2);     overThresh = 1'b0;
    waitTo(n + B + 2 + H + 2);

    // Scenario C: disable clears chop and blanking, comparator ignored (R9)
    n = cycCnt;
    push(n + 1, 0, 1, "R2");
    push(n + 50, 0, 1, "R9");
    push(n + 51, 0, 0, "R9");
    push(n + 61, 0, 0, "R9");
    push(n + 65, 1, 0, "R9");
    push(n + 72, 0, 1, "R9");
    push(n + 72 + N, 0, 0, "R3");
    push(n + 71 + H, 1, 0, "R7");
    push(n + 72 + H, 1, 1, "R7");
    overThresh = 1'b1;
    waitTo(n + 1);  overThresh = 1'b0;
    waitTo(n + 50); bridgeEn = 1'b0;
    waitTo(n + 60); overThresh = 1'b1;
    waitTo(n + 61); overThresh = 1'b0;
    waitTo(n + 62); switchEvt = 1'b1;
    waitTo(n + 63); switchEvt = 1'b0;
    waitTo(n + 70); bridgeEn = 1'b1;
    waitTo(n + 71); overThresh = 1'b1;
    waitTo(n + 72); overThresh = 1'b0;
    waitTo(n + 72 + H + 2);

    // Scenario D: flag timer completes while disabled (R9)
    n = cycCnt;
    push(n + 1, 0, 1, "R2");
    push(n + 6, 0, 0, "R9");
    push(n + H, 1, 0, "R9");
    push(n + 1 + H, 1, 1, "R9");
    overThresh = 1'b1;
    waitTo(n + 1); overThresh = 1'b0;
    waitTo(n + 5); bridgeEn = 1'b0;
    waitTo(n + H + 4); bridgeEn = 1'b1;

    while (sbq.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule